// File: doc/BRIEF.md
# Eight-Lane Vector ALU Slot

This block is one SIMD execution slot. Each transaction carries an opcode, an operand-count field, a base destination index and up to three source vectors of eight 32-bit lanes, or a single scalar word for broadcast. It returns an eight-lane result vector with the same base index and a write-enable. Lane `i` of the result is meant for scratch address `base + i`. Gathering the operands, the scratch bank and bundle decode all sit outside the block. A bundle may hold up to six copies of this slot.

Every lane repeats the scalar ALU semantics. These are add, subtract, multiply, floor divide, ceiling divide, XOR, AND, OR, left shift, right shift, modulo, less-than and equality, all unsigned and wrapping modulo 2^32. The slot adds two operations on top of these: a broadcast of one scalar into all lanes, and a lane-wise multiply-add.

Operands enter on a valid/ready handshake. A transaction is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. Its result appears on the output port from the following cycle. The result is therefore written at the end of the issue cycle, after every operand has been read. The output follows valid/ready as well. While `res_valid` is high and `res_ready` is low, the result holds steady and `in_ready` stays low. When the consumer takes a result, the slot can accept a new transaction on that same edge.

Top module: `vec_alu_slot`

## Requirements
- R1: Opcodes 0 (add), 1 (subtract) and 2 (multiply) give per lane `a[i]+b[i]`, `a[i]-b[i]` and `a[i]*b[i]`, each kept to the low 32 bits.
- R2: Opcodes 5 (XOR), 6 (AND), 7 (OR), 8 (left shift) and 9 (right shift, logical) act per lane. A shift amount of 32 or more gives 0.
- R3: Opcode 11 (unsigned less-than) and opcode 12 (equality) give 1 or 0 in each lane.
- R4: Opcode 3 gives `a/b` rounded down, opcode 4 gives `a/b` rounded up, and opcode 10 gives `a mod b`. A lane whose divisor is 0 yields 0 and sets that lane's error bit. `res_err` is the OR of the lane error bits.
- R5: Opcode 13 (broadcast) copies the scalar input `in_scalar` into all eight lanes.
- R6: Opcode 14 (multiply-add) gives `a[i]*b[i]+c[i]` per lane, wrapping modulo 2^32 after the multiply and again after the add.
- R7: The operand-count field `in_nsrc` must be 1 for broadcast, 3 for multiply-add and 2 for opcodes 0 to 12. Opcode 15 is undefined. A mismatch or an undefined opcode gives `res_we`=0, all-zero data and `res_err`=0.
- R8: A transaction accepted on an edge appears on the output from that edge, with `res_valid`=1 and the same destination index.
- R9: `in_ready` is high exactly when no result is pending or the pending result is being taken. A pending result that is not taken holds its index, data, write-enable and error unchanged.
- R10: After reset, `res_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Source transaction present |
| in_ready | output | 1 | Slot can accept a transaction |
| in_op | input | 4 | Opcode |
| in_nsrc | input | 2 | Operand-count field (1, 2 or 3) |
| in_dst | input | 12 | Base destination index |
| in_a | input | 256 | Source vector A, lane i at bits 32i+31:32i |
| in_b | input | 256 | Source vector B |
| in_c | input | 256 | Source vector C (multiply-add addend) |
| in_scalar | input | 32 | Scalar source for broadcast |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_dst | output | 12 | Base destination index of the result |
| res_we | output | 1 | Result should be written |
| res_data | output | 256 | Result vector, lane i at bits 32i+31:32i |
| res_err | output | 1 | Some lane divided by zero |

## Verification
The bench generates operand vectors at random, with each lane drawn separately. This shows whether lanes are computed independently rather than copied from lane 0. The divisor and shift lanes are drawn from a mixed pool of zeros, small values, values of 32 and above, and full-range words. Mixing zero-divisor lanes with normal lanes in one vector checks that the error bit stays local to its lane while the flag still combines all lanes. Correct and wrong operand counts are both sent for every opcode, which separates rejected transactions from zero results. A directed back-pressure sequence checks that a stalled result holds and that a queued input is neither lost nor allowed to overtake the stalled result.

// File: rtl/vec_alu_pkg.sv
package vec_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_MUL   = 4'd2,
    OP_DIV   = 4'd3,
    OP_CDIV  = 4'd4,
    OP_XOR   = 4'd5,
    OP_AND   = 4'd6,
    OP_OR    = 4'd7,
    OP_SHL   = 4'd8,
    OP_SHR   = 4'd9,
    OP_MOD   = 4'd10,
    OP_LT    = 4'd11,
    OP_EQ    = 4'd12,
    OP_BCAST = 4'd13,
    OP_FMA   = 4'd14,
    OP_NONE  = 4'd15
  } vop_e;

  localparam int unsigned OP_W   = 4;
  localparam int unsigned NSRC_W = 2;
endpackage

// File: rtl/vec_form_check.sv
module vec_form_check
  import vec_alu_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [NSRC_W-1:0] nsrc,
  output logic              form_ok
);
  logic [NSRC_W-1:0] need;
  logic              known;

  always_comb begin
    known = 1'b1;
    need  = 2'd2;
    case (vop_e'(op))
      OP_BCAST: need = 2'd1;
      OP_FMA:   need = 2'd3;
      OP_NONE:  known = 1'b0;
      default:  need = 2'd2;
    endcase
    form_ok = known && (nsrc == need);
  end
endmodule

// File: rtl/vec_lane.sv
module vec_lane
  import vec_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [W-1:0]    c,
  input  logic [W-1:0]    s,
  output logic [W-1:0]    res,
  output logic            err
);
  localparam int unsigned SHW = $clog2(W);

  logic          b_zero;
  logic          sh_big;
  logic [W-1:0]  quot;
  logic [W-1:0]  rem;
  logic [W-1:0]  prod;

  assign b_zero = (b == '0);
  assign sh_big = (b >= W);
  assign quot   = b_zero ? '0 : a / b;
  assign rem    = b_zero ? '0 : a % b;
  assign prod   = a * b;

  always_comb begin
    res = '0;
    err = 1'b0;
    case (vop_e'(op))
      OP_ADD:   res = a + b;
      OP_SUB:   res = a - b;
      OP_MUL:   res = prod;
      OP_DIV: begin
        res = quot;
        err = b_zero;
      end
      OP_CDIV: begin
        res = quot + ((rem != '0) ? W'(1) : W'(0));
        err = b_zero;
      end
      OP_MOD: begin
        res = rem;
        err = b_zero;
      end
      OP_XOR:   res = a ^ b;
      OP_AND:   res = a & b;
      OP_OR:    res = a | b;
      OP_SHL:   res = sh_big ? '0 : (a << b[SHW-1:0]);
      OP_SHR:   res = sh_big ? '0 : (a >> b[SHW-1:0]);
      OP_LT:    res = (a < b) ? W'(1) : W'(0);
      OP_EQ:    res = (a == b) ? W'(1) : W'(0);
      OP_BCAST: res = s;
      OP_FMA:   res = prod + c;
      default: begin
        res = '0;
        err = 1'b0;
      end
    endcase
  end

  // R4: an error bit only ever comes from a divide-family opcode with a zero divisor
  a_r4_err_source: assert property (@(posedge clk) disable iff (rst)
    err |-> (b == '0) && (op == OP_DIV || op == OP_CDIV || op == OP_MOD));

  // R4: a divide-by-zero lane yields zero
  a_r4_zero_result: assert property (@(posedge clk) disable iff (rst)
    err |-> (res == '0));
endmodule

// File: rtl/vec_out_stage.sv
module vec_out_stage #(
  parameter int unsigned DW = 12,
  parameter int unsigned VW = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [DW-1:0] nxt_dst,
  input  logic          nxt_we,
  input  logic [VW-1:0] nxt_data,
  input  logic          nxt_err,
  input  logic          res_ready,
  output logic          res_valid,
  output logic [DW-1:0] res_dst,
  output logic          res_we,
  output logic [VW-1:0] res_data,
  output logic          res_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_dst   <= '0;
      res_we    <= 1'b0;
      res_data  <= '0;
      res_err   <= 1'b0;
    end else begin
      if (take) begin
        res_valid <= 1'b1;
        res_dst   <= nxt_dst;
        res_we    <= nxt_we;
        res_data  <= nxt_data;
        res_err   <= nxt_err;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  // R9: a stalled result holds all of its fields
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_dst) && $stable(res_data)
                                   && $stable(res_we) && $stable(res_err)));

  // R7: a rejected transaction carries no data and no error
  a_r7_reject_clean: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_we) |-> (res_data == '0 && !res_err));
endmodule

// File: rtl/vec_alu_slot.sv
module vec_alu_slot
  import vec_alu_pkg::*;
#(
  parameter int unsigned LANES = 8,
  parameter int unsigned W     = 32,
  parameter int unsigned DW    = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [OP_W-1:0]      in_op,
  input  logic [NSRC_W-1:0]    in_nsrc,
  input  logic [DW-1:0]        in_dst,
  input  logic [LANES*W-1:0]   in_a,
  input  logic [LANES*W-1:0]   in_b,
  input  logic [LANES*W-1:0]   in_c,
  input  logic [W-1:0]         in_scalar,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic [DW-1:0]        res_dst,
  output logic                 res_we,
  output logic [LANES*W-1:0]   res_data,
  output logic                 res_err
);
  localparam int unsigned VW = LANES * W;

  logic             form_ok;
  logic [VW-1:0]    lane_res;
  logic [LANES-1:0] lane_err;
  logic             take;
  logic [VW-1:0]    nxt_data;
  logic             nxt_err;

  vec_form_check u_form (
    .op      (in_op),
    .nsrc    (in_nsrc),
    .form_ok (form_ok)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vec_lane #(.W(W)) u_lane (
      .clk (clk),
      .rst (rst),
      .op  (in_op),
      .a   (in_a[g*W +: W]),
      .b   (in_b[g*W +: W]),
      .c   (in_c[g*W +: W]),
      .s   (in_scalar),
      .res (lane_res[g*W +: W]),
      .err (lane_err[g])
    );
  end

  assign in_ready = !res_valid || res_ready;
  assign take     = in_valid && in_ready;
  assign nxt_data = form_ok ? lane_res : '0;
  assign nxt_err  = form_ok && (|lane_err);

  vec_out_stage #(.DW(DW), .VW(VW)) u_out (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .nxt_dst   (in_dst),
    .nxt_we    (form_ok),
    .nxt_data  (nxt_data),
    .nxt_err   (nxt_err),
    .res_ready (res_ready),
    .res_valid (res_valid),
    .res_dst   (res_dst),
    .res_we    (res_we),
    .res_data  (res_data),
    .res_err   (res_err)
  );

  // R8: a result appears only after an accepted transaction
  a_r8_rise_after_accept: assert property (@(posedge clk) disable iff (rst)
    $rose(res_valid) |-> $past(in_valid && in_ready));

  // R8: the destination index follows the accepted transaction
  a_r8_dst_follows: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (res_valid && res_dst == $past(in_dst)));

  // R9: no acceptance while a result is stalled
  a_r9_stall_blocks: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |-> !in_ready);
endmodule

// File: tb/test_vec_alu_slot.sv
module test_vec_alu_slot;
  localparam int LANES = 8;
  localparam int W     = 32;
  localparam int DW    = 12;
  localparam int VW    = LANES * W;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [3:0]      in_op = '0;
  logic [1:0]      in_nsrc = '0;
  logic [DW-1:0]   in_dst = '0;
  logic [VW-1:0]   in_a = '0, in_b = '0, in_c = '0;
  logic [W-1:0]    in_scalar = '0;
  logic            res_valid;
  logic            res_ready = 1'b1;
  logic [DW-1:0]   res_dst;
  logic            res_we;
  logic [VW-1:0]   res_data;
  logic            res_err;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #5 clk = ~clk;

  vec_alu_slot i_vec_alu_slot (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_nsrc(in_nsrc), .in_dst(in_dst),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_scalar(in_scalar),
    .res_valid(res_valid), .res_ready(res_ready), .res_dst(res_dst),
    .res_we(res_we), .res_data(res_data), .res_err(res_err)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 100000", cycles);
      finish_run();
    end
  end

  task automatic check(input bit ok, input string tag, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int need_count(input int op);
    if (op == 13) return 1;
    if (op == 14) return 3;
    return 2;
  endfunction

  function automatic logic [W-1:0] ref_lane(input int op, input logic [W-1:0] a,
      input logic [W-1:0] b, input logic [W-1:0] c, input logic [W-1:0] s,
      output bit e);
    longint unsigned la = a, lb = b, lc = c, r;
    e = 0;
    r = 0;
    case (op)
      0:  r = la + lb;
      1:  r = la - lb;
      2:  r = la * lb;
      3:  if (lb == 0) e = 1; else r = la / lb;
      4:  if (lb == 0) e = 1; else r = (la + lb - 1) / lb;
      5:  r = la ^ lb;
      6:  r = la & lb;
      7:  r = la | lb;
      8:  r = (lb >= 32) ? 0 : (la << lb);
      9:  r = (lb >= 32) ? 0 : (la >> lb);
      10: if (lb == 0) e = 1; else r = la % lb;
      11: r = (la < lb) ? 1 : 0;
      12: r = (la == lb) ? 1 : 0;
      13: r = s;
      14: r = ((la * lb) & 64'hFFFF_FFFF) + lc;
      default: r = 0;
    endcase
    return r[W-1:0];
  endfunction

  task automatic expect_of(input int op, input int ns, output logic [VW-1:0] d,
                           output bit we, output bit er);
    bit e;
    d  = '0;
    er = 0;
    we = (op != 15) && (ns == need_count(op));
    if (we) begin
      for (int i = 0; i < LANES; i++) begin
        d[i*W +: W] = ref_lane(op, in_a[i*W +: W], in_b[i*W +: W],
                               in_c[i*W +: W], in_scalar, e);
        er |= e;
      end
    end
  endtask

  function automatic logic [W-1:0] pick_b();
    case ($urandom % 5)
      0: return '0;
      1: return $urandom % 8;
      2: return 32 + ($urandom % 8);
      3: return $urandom % 40;
      default: return $urandom;
    endcase
  endfunction

  task automatic present(input int op, input int ns, input int dst);
    in_op   = op[3:0];
    in_nsrc = ns[1:0];
    in_dst  = dst[DW-1:0];
    in_valid = 1'b1;
  endtask

  task automatic run_one(input int op, input int ns, input int dst, input string tag);
    logic [VW-1:0] d;
    bit we, er;
    @(negedge clk);
    present(op, ns, dst);
    expect_of(op, ns, d, we, er);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(res_valid && res_dst == dst[DW-1:0] && res_we == we && res_err == er && res_data == d,
          $sformatf("%s op=%0d ns=%0d we=%0b/%0b err=%0b/%0b", tag, op, ns, res_we, we, res_err, er),
          res_data, d);
  endtask

  function automatic string tag_for(input int op);
    case (op)
      0, 1, 2:       return "R1";
      5, 6, 7, 8, 9: return "R2";
      11, 12:        return "R3";
      3, 4, 10:      return "R4";
      13:            return "R5";
      14:            return "R6";
      default:       return "R7";
    endcase
  endfunction

  initial begin
    logic [VW-1:0] held;
    logic [VW-1:0] d;
    bit we, er;
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(!res_valid && in_ready, "R10 reset state", {254'b0, res_valid, in_ready}, 256'd1);

    // R1: wrap on add and multiply
    in_a = {LANES{32'hFFFF_FFFF}};
    in_b = {LANES{32'h0000_0003}};
    run_one(0, 2, 7, "R1 add wrap");
    run_one(2, 2, 7, "R1 mul wrap");
    run_one(1, 2, 7, "R1 sub");
    // R2: shift by exactly 32 and 31
    for (int i = 0; i < LANES; i++) in_b[i*W +: W] = (i % 2) ? 32 : 31;
    run_one(8, 2, 9, "R2 shl edge");
    run_one(9, 2, 9, "R2 shr edge");
    // R3: equal lanes
    in_b = in_a;
    run_one(12, 2, 1, "R3 eq all");
    run_one(11, 2, 1, "R3 lt none");
    // R4: zero divisor in one lane only
    for (int i = 0; i < LANES; i++) in_b[i*W +: W] = (i == 5) ? 0 : i + 2;
    in_a = {LANES{32'd17}};
    run_one(3, 2, 4, "R4 div");
    run_one(4, 2, 4, "R4 cdiv");
    run_one(10, 2, 4, "R4 mod");
    // R5: broadcast
    in_scalar = 32'hDEAD_BEEF;
    run_one(13, 1, 100, "R5 bcast");
    // R6: multiply-add double wrap
    in_a = {LANES{32'h8000_0001}};
    in_b = {LANES{32'h0000_0002}};
    in_c = {LANES{32'hFFFF_FFFF}};
    run_one(14, 3, 200, "R6 fma wrap");
    // R7: wrong counts and undefined opcode
    run_one(14, 2, 5, "R7 fma ns2");
    run_one(13, 2, 5, "R7 bcast ns2");
    run_one(0, 0, 5, "R7 add ns0");
    run_one(15, 2, 5, "R7 undefined");

    // R9: back-pressure
    @(negedge clk);
    res_ready = 1'b0;
    in_a = {LANES{32'd10}};
    in_b = {LANES{32'd20}};
    present(0, 2, 33);
    @(posedge clk);
    @(negedge clk);
    held = res_data;
    present(1, 2, 44);
    expect_of(1, 2, d, we, er);
    check(!in_ready && res_valid && res_dst == 33, "R9 stall blocks input",
          {255'b0, in_ready}, 256'd0);
    repeat (2) @(negedge clk);
    check(res_valid && res_dst == 33 && res_data == held && res_data == {LANES{32'd30}},
          "R9 stalled result held", res_data, {LANES{32'd30}});
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    // R8: queued input accepted on the edge the held result left
    check(res_valid && res_dst == 44 && res_data == d, "R8 R9 queued input follows",
          res_data, d);
    @(negedge clk);
    check(!res_valid && in_ready, "R9 drains", {255'b0, res_valid}, 256'd0);

    // random mix
    for (int k = 0; k < 400; k++) begin
      int op, ns;
      op = $urandom % 16;
      ns = (($urandom % 4) == 0) ? ($urandom % 4) : need_count(op);
      for (int i = 0; i < LANES; i++) begin
        in_a[i*W +: W] = (($urandom % 4) == 0) ? ($urandom % 50) : $urandom;
        in_b[i*W +: W] = pick_b();
        in_c[i*W +: W] = $urandom;
      end
      in_scalar = $urandom;
      run_one(op, ns, $urandom % 4096, $sformatf("%s random", tag_for(op)));
    end
    finish_run();
  end
endmodule